// File: doc/BRIEF.md
# Serial Transmit/Receive Core with Internal Loopback

This block is a byte-wide asynchronous serial port with a small register interface. A write to the data register queues a byte for the transmitter, and received bytes are read from the same address. A line-status register reports data ready, overrun, parity and framing errors, and the two transmitter idle conditions. A modem-control register drives a request-to-send line. A modem-status register shows the clear-to-send state. One interrupt line combines three enable-gated sources.

Setting the loopback bit in the modem-control register reroutes the serial path for self-test. The transmit shifter output feeds the receive shifter directly, and the external serial output is parked at the mark level. The external serial input and the external clear-to-send input are ignored. The request-to-send control bit appears as the clear-to-send status, and the external request-to-send pin is parked inactive. Interrupts keep working under the same enables. A change of the loopback bit is applied only while both shifters are idle, so a frame in flight is never cut in two.

Top module: `uart_lb_core`

## Requirements
- R1: After reset, line status (address 4) reads 0x60, txd_o is 1, rts_n_o is 1 and irq_o is 0.
- R2: A byte written to address 0 is sent on txd_o as a low start bit, 8 data bits LSB first, an optional parity bit and one high stop bit. Each bit lasts OVS ticks of DIV clocks.
- R3: The receiver samples each bit near its middle and stores the byte in the receive buffer (read at address 0). It sets line-status bit 0 (data ready), and reading address 0 clears that bit.
- R4: With modem-control bit 4 set (loopback), a byte written to address 0 is received internally and reads back from address 0.
- R5: In loopback, txd_o stays 1 for the whole frame and activity on rxd_i produces no received character.
- R6: In loopback, rts_n_o is 1, modem-status bit 0 equals modem-control bit 0, and cts_n_i has no effect. Otherwise rts_n_o is the inverse of modem-control bit 0 and modem-status bit 0 is the inverse of cts_n_i.
- R7: A change of the loopback bit takes effect only when both the transmitter and the receiver are idle.
- R8: Line-control bit 0 enables parity and bit 1 selects even parity (0 = odd). A received parity mismatch sets line-status bit 2.
- R9: A stop bit received as 0 sets line-status bit 3, and the byte is still stored.
- R10: A character completed while data ready is set replaces the buffer and sets line-status bit 1 (overrun).
- R11: Reading line status (address 4) clears bits 1, 2 and 3.
- R12: irq_o is high when interrupt-enable bit 0 and data ready are both set, or when enable bit 1 is set and the transmit holding register is empty, or when enable bit 2 is set and any error bit is set. This holds in loopback as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| txd_o | output | 1 | External serial output |
| rxd_i | input | 1 | External serial input |
| rts_n_o | output | 1 | Request-to-send, active low |
| cts_n_i | input | 1 | Clear-to-send, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives garbage on the serial input and asserts clear-to-send while loopback is on. A design that left either path connected would then report a stray character or a wrong modem status. It watches txd_o on every cycle of a looped frame, so even a single leaked start bit shows up. It turns on loopback halfway through a normal transmission: a design that switches at once would release rts_n_o too early and cut the frame. It also exercises overrun with two looped bytes, bad parity and a stop bit forced low, and the clear-on-read of the error bits. A design with wrong buffer-replace or clear-on-read behaviour would read back the wrong byte or stale flags.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } ser_st_e;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_IEN   = 3'd1;
    localparam logic [2:0] A_LCTL  = 3'd2;
    localparam logic [2:0] A_MCTL  = 3'd3;
    localparam logic [2:0] A_LSTAT = 3'd4;
    localparam logic [2:0] A_MSTAT = 3'd5;

    localparam int BYTE_W   = 8;
    localparam int MC_RTS   = 0;
    localparam int MC_LOOP  = 4;
endpackage

// File: rtl/uart_lb_tick.sv
module uart_lb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t d, q;

    always_comb begin
        d = q;
        if (q.cnt == CW'(DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;
endmodule

// File: rtl/uart_lb_tx.sv
module uart_lb_tx
    import uart_lb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    output logic              txd_o,
    output logic              busy_o
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(BYTE_W);

    typedef struct packed {
        ser_st_e           st;
        logic [TW-1:0]     tcnt;
        logic [BW-1:0]     bitn;
        logic [BYTE_W-1:0] sh;
        logic              pen;
        logic              pbit;
        logic              txd;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (q.st == S_IDLE) begin
            d.txd = 1'b1;
            if (start_i) begin
                d.st   = S_START;
                d.sh   = data_i;
                d.tcnt = '0;
                d.bitn = '0;
                d.txd  = 1'b0;
                d.pen  = par_en_i;
                d.pbit = (^data_i) ^ !par_even_i;
            end
        end else if (tick_i) begin
            if (q.tcnt == TW'(OVS - 1)) begin
                d.tcnt = '0;
                case (q.st)
                    S_START: begin
                        d.st  = S_DATA;
                        d.txd = q.sh[0];
                    end
                    S_DATA: begin
                        if (q.bitn == BW'(BYTE_W - 1)) begin
                            if (q.pen) begin
                                d.st  = S_PAR;
                                d.txd = q.pbit;
                            end else begin
                                d.st  = S_STOP;
                                d.txd = 1'b1;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.sh   = {1'b0, q.sh[BYTE_W-1:1]};
                            d.txd  = q.sh[1];
                        end
                    end
                    S_PAR: begin
                        d.st  = S_STOP;
                        d.txd = 1'b1;
                    end
                    default: begin
                        d.st  = S_IDLE;
                        d.txd = 1'b1;
                    end
                endcase
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.txd  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd_o  = q.txd;
    assign busy_o = (q.st != S_IDLE);

    // R2: line rests at mark whenever the shifter is idle
    a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> q.txd);

    // R2: a frame always opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start_i) |=> (q.st == S_START && !q.txd));
endmodule

// File: rtl/uart_lb_rx.sv
module uart_lb_rx
    import uart_lb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              busy_o
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(BYTE_W);

    typedef struct packed {
        ser_st_e           st;
        logic [TW-1:0]     tcnt;
        logic [BW-1:0]     bitn;
        logic [BYTE_W-1:0] sh;
        logic              pbad;
        logic              done;
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick_i) begin
            case (q.st)
                S_IDLE: begin
                    if (!line_i) begin
                        d.st   = S_START;
                        d.tcnt = '0;
                        d.pbad = 1'b0;
                    end
                end
                S_START: begin
                    if (q.tcnt == TW'(OVS / 2 - 1)) begin
                        d.tcnt = '0;
                        d.bitn = '0;
                        d.st   = line_i ? S_IDLE : S_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt = '0;
                        d.sh   = {line_i, q.sh[BYTE_W-1:1]};
                        if (q.bitn == BW'(BYTE_W - 1))
                            d.st = par_en_i ? S_PAR : S_STOP;
                        else
                            d.bitn = q.bitn + 1'b1;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt = '0;
                        d.pbad = (line_i != ((^q.sh) ^ !par_even_i));
                        d.st   = S_STOP;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt = '0;
                        d.done = 1'b1;
                        d.data = q.sh;
                        d.perr = q.pbad;
                        d.ferr = !line_i;
                        d.st   = S_IDLE;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign data_o = q.data;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;
    assign busy_o = (q.st != S_IDLE);

    // R3: completion is a single-cycle pulse that leaves the shifter idle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!d.done && q.st == S_IDLE));
endmodule

// File: rtl/uart_lb_core.sv
module uart_lb_core
    import uart_lb_pkg::*;
#(
    parameter int DIV = 4,
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd_o,
    input  logic       rxd_i,
    output logic       rts_n_o,
    input  logic       cts_n_i,
    output logic       irq_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] thr;
        logic              thr_full;
        logic [BYTE_W-1:0] rbr;
        logic              dr;
        logic              oe;
        logic              pe;
        logic              fe;
        logic [2:0]        ien;
        logic              pen;
        logic              peven;
        logic              rts;
        logic              lb_req;
        logic              lb_act;
        logic              rx_s1;
        logic              rx_s2;
        logic              cts_s1;
        logic              cts_s2;
    } core_t;

    core_t r_d, r_q;

    logic              tick;
    logic              tx_line, tx_busy, tx_load;
    logic              rx_line, rx_busy, rx_done, rx_perr, rx_ferr;
    logic [BYTE_W-1:0] rx_data;
    logic              cts_stat;

    uart_lb_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    uart_lb_tx #(.OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (tx_load),
        .data_i     (r_q.thr),
        .par_en_i   (r_q.pen),
        .par_even_i (r_q.peven),
        .txd_o      (tx_line),
        .busy_o     (tx_busy)
    );

    uart_lb_rx #(.OVS(OVS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .line_i     (rx_line),
        .par_en_i   (r_q.pen),
        .par_even_i (r_q.peven),
        .done_o     (rx_done),
        .data_o     (rx_data),
        .perr_o     (rx_perr),
        .ferr_o     (rx_ferr),
        .busy_o     (rx_busy)
    );

    // loopback routing
    assign rx_line  = r_q.lb_act ? tx_line : r_q.rx_s2;
    assign txd_o    = r_q.lb_act | tx_line;
    assign rts_n_o  = r_q.lb_act | !r_q.rts;
    assign cts_stat = r_q.lb_act ? r_q.rts : !r_q.cts_s2;
    assign tx_load  = r_q.thr_full & !tx_busy;

    always_comb begin
        r_d        = r_q;
        r_d.rx_s1  = rxd_i;
        r_d.rx_s2  = r_q.rx_s1;
        r_d.cts_s1 = cts_n_i;
        r_d.cts_s2 = r_q.cts_s1;

        if (tx_load) r_d.thr_full = 1'b0;

        if (!tx_busy && !rx_busy) r_d.lb_act = r_q.lb_req;

        if (wr_en) begin
            case (addr)
                A_DATA: begin
                    r_d.thr      = wdata;
                    r_d.thr_full = 1'b1;
                end
                A_IEN:  r_d.ien = wdata[2:0];
                A_LCTL: begin
                    r_d.pen   = wdata[0];
                    r_d.peven = wdata[1];
                end
                A_MCTL: begin
                    r_d.rts    = wdata[MC_RTS];
                    r_d.lb_req = wdata[MC_LOOP];
                end
                default: ;
            endcase
        end

        if (rd_en && addr == A_DATA) r_d.dr = 1'b0;
        if (rd_en && addr == A_LSTAT) begin
            r_d.oe = 1'b0;
            r_d.pe = 1'b0;
            r_d.fe = 1'b0;
        end

        if (rx_done) begin
            r_d.rbr = rx_data;
            r_d.oe  = r_d.oe | (r_q.dr & !(rd_en && addr == A_DATA));
            r_d.dr  = 1'b1;
            r_d.pe  = rx_perr;
            r_d.fe  = rx_ferr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.rx_s1  <= 1'b1;
            r_q.rx_s2  <= 1'b1;
            r_q.cts_s1 <= 1'b1;
            r_q.cts_s2 <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = r_q.rbr;
            A_IEN:   rdata = {5'b0, r_q.ien};
            A_LCTL:  rdata = {6'b0, r_q.peven, r_q.pen};
            A_MCTL:  rdata = {3'b0, r_q.lb_req, 3'b0, r_q.rts};
            A_LSTAT: rdata = {1'b0, !r_q.thr_full && !tx_busy, !r_q.thr_full,
                              1'b0, r_q.fe, r_q.pe, r_q.oe, r_q.dr};
            A_MSTAT: rdata = {7'b0, cts_stat};
            default: rdata = 8'h00;
        endcase
    end

    assign irq_o = (r_q.ien[0] & r_q.dr)
                 | (r_q.ien[1] & !r_q.thr_full)
                 | (r_q.ien[2] & (r_q.oe | r_q.pe | r_q.fe));

    // R3: a completed character raises data ready on the next cycle
    a_r3_dr_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> r_q.dr);

    // R10: a character landing on an unread buffer flags overrun
    a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && r_q.dr && !(rd_en && addr == A_DATA)) |=> r_q.oe);

    // R11: a status read with no new character leaves the error flags clear
    a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_LSTAT && !rx_done) |=> (!r_q.oe && !r_q.pe && !r_q.fe));

    // R7: the routing only switches while both shifters were idle
    a_r7_lb_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.lb_act != $past(r_q.lb_act)) |-> $past(!tx_busy && !rx_busy));
endmodule

// File: tb/uart_lb_core_tb.sv
module uart_lb_core_tb;
    localparam int DIV  = 4;
    localparam int OVS  = 16;
    localparam int BITC = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       txd_o;
    logic       rxd_i = 1'b1;
    logic       rts_n_o;
    logic       cts_n_i = 1'b1;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    bit watch_tx = 1'b0;
    int tx_leak = 0;

    always #2.5 clk = ~clk;

    uart_lb_core #(.DIV(DIV), .OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd_o(txd_o), .rxd_i(rxd_i),
        .rts_n_o(rts_n_o), .cts_n_i(cts_n_i), .irq_o(irq_o)
    );

    always @(negedge clk) if (watch_tx && txd_o !== 1'b1) tx_leak++;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit use_par, input bit pbit, input bit stopb);
        @(negedge clk);
        rxd_i = 1'b0; idle(BITC);
        for (int i = 0; i < 8; i++) begin rxd_i = b[i]; idle(BITC); end
        if (use_par) begin rxd_i = pbit; idle(BITC); end
        rxd_i = stopb;
        idle(stopb ? BITC : (BITC * 3) / 4);
        rxd_i = 1'b1;
        idle(2 * BITC);
    endtask

    task automatic grab_tx(output logic [7:0] b);
        int n = 0;
        b = 8'h00;
        while (txd_o !== 1'b0 && n < 4 * BITC) begin @(negedge clk); n++; end
        idle(BITC / 2);
        for (int i = 0; i < 8; i++) begin idle(BITC); b[i] = txd_o; end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd4, v); chk("R1 line status", v, 8'h60);
        chk("R1 txd_o", {7'b0, txd_o}, 8'h01);
        chk("R1 rts_n_o", {7'b0, rts_n_o}, 8'h01);
        chk("R1 irq_o", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_loopback;
        logic [7:0] v;
        wr(3'd3, 8'h10); idle(4);
        rxd_i = 1'b0;
        watch_tx = 1'b1; tx_leak = 0;
        wr(3'd0, 8'hA5); idle(13 * BITC);
        rd(3'd4, v); chk("R4 status after looped byte", v, 8'h61);
        rd(3'd0, v); chk("R4 looped byte A5", v, 8'hA5);
        wr(3'd0, 8'h3C); idle(13 * BITC);
        rd(3'd0, v); chk("R4 looped byte 3C", v, 8'h3C);
        watch_tx = 1'b0;
        chk("R5 txd_o held at mark", tx_leak[7:0], 8'h00);
        rd(3'd4, v); chk("R5 rxd_i ignored", v, 8'h60);
        rxd_i = 1'b1; idle(4);
    endtask

    task automatic t_modem;
        logic [7:0] v;
        cts_n_i = 1'b1;
        wr(3'd3, 8'h11); idle(4);
        rd(3'd5, v); chk("R6 loop cts from rts=1", v, 8'h01);
        chk("R6 loop rts_n_o parked", {7'b0, rts_n_o}, 8'h01);
        cts_n_i = 1'b0;
        wr(3'd3, 8'h10); idle(4);
        rd(3'd5, v); chk("R6 loop cts from rts=0", v, 8'h00);
        wr(3'd3, 8'h01); idle(4);
        chk("R6 normal rts_n_o", {7'b0, rts_n_o}, 8'h00);
        rd(3'd5, v); chk("R6 normal cts asserted", v, 8'h01);
        cts_n_i = 1'b1; idle(4);
        rd(3'd5, v); chk("R6 normal cts negated", v, 8'h00);
        wr(3'd3, 8'h00); idle(4);
    endtask

    task automatic t_normal;
        logic [7:0] v;
        wr(3'd0, 8'h5A);
        grab_tx(v); chk("R2 serial out 5A", v, 8'h5A);
        idle(3 * BITC);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        rd(3'd4, v); chk("R3 data ready", v, 8'h61);
        rd(3'd0, v); chk("R3 received C3", v, 8'hC3);
        rd(3'd4, v); chk("R3 ready cleared by read", v, 8'h60);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        wr(3'd2, 8'h03);
        wr(3'd3, 8'h10); idle(4);
        wr(3'd0, 8'h07); idle(14 * BITC);
        rd(3'd4, v); chk("R8 looped even parity clean", v, 8'h61);
        rd(3'd0, v); chk("R8 looped parity byte", v, 8'h07);
        wr(3'd3, 8'h00); idle(4);
        send_frame(8'h07, 1'b1, 1'b0, 1'b1);
        rd(3'd4, v); chk("R8 even parity mismatch", v, 8'h65);
        rd(3'd4, v); chk("R11 parity flag cleared", v, 8'h61);
        rd(3'd0, v);
        wr(3'd2, 8'h01);
        send_frame(8'h07, 1'b1, 1'b0, 1'b1);
        rd(3'd4, v); chk("R8 odd parity match", v, 8'h61);
        rd(3'd0, v);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_framing;
        logic [7:0] v;
        send_frame(8'h81, 1'b0, 1'b0, 1'b0);
        rd(3'd4, v); chk("R9 framing flag", v, 8'h69);
        rd(3'd0, v); chk("R9 byte kept", v, 8'h81);
        rd(3'd4, v); chk("R11 framing flag cleared", v, 8'h60);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        wr(3'd3, 8'h10); idle(4);
        wr(3'd0, 8'h11); idle(13 * BITC);
        wr(3'd0, 8'h22); idle(13 * BITC);
        rd(3'd4, v); chk("R10 overrun flag", v, 8'h63);
        rd(3'd0, v); chk("R10 newer byte kept", v, 8'h22);
        rd(3'd4, v); chk("R11 overrun cleared", v, 8'h60);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h44); idle(13 * BITC);
        chk("R12 rx irq in loopback", {7'b0, irq_o}, 8'h01);
        rd(3'd0, v); idle(1);
        chk("R12 irq drops on read", {7'b0, irq_o}, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h45); idle(13 * BITC);
        chk("R12 masked rx irq", {7'b0, irq_o}, 8'h00);
        rd(3'd0, v);
        wr(3'd1, 8'h02); idle(1);
        chk("R12 tx empty irq", {7'b0, irq_o}, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00); idle(4);
    endtask

    task automatic t_defer;
        logic [7:0] v;
        wr(3'd3, 8'h01); idle(4);
        wr(3'd0, 8'h55); idle(2 * BITC);
        wr(3'd3, 8'h11); idle(4);
        chk("R7 rts_n_o unchanged mid frame", {7'b0, rts_n_o}, 8'h00);
        idle(12 * BITC);
        chk("R7 loopback applied after idle", {7'b0, rts_n_o}, 8'h01);
        rd(3'd4, v); chk("R7 nothing looped from old frame", v, 8'h60);
        wr(3'd3, 8'h00); idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_loopback();
        t_modem();
        t_normal();
        t_parity();
        t_framing();
        t_overrun();
        t_irq();
        t_defer();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule